// File: doc/BRIEF.md
# Mixed-Length Instruction Stream Aligner

The aligner sits between an instruction fetch unit and a decoder. The fetch side supplies 32-bit words, each naturally aligned. Those words hold a packed stream of 16-bit and 32-bit instructions at halfword granularity. The aligner emits one whole instruction per handshake. Each instruction comes with a flag giving its length and with the byte address of its first halfword.

Halfwords that have not been used yet stay in a small shift buffer. This lets a 32-bit instruction whose first half ends one fetch word finish with the first halfword of the next word.

A flush drops everything in the buffer and restarts the stream at a new address. That address may be halfword aligned. In that case the lower halfword of the first word fetched after the flush is thrown away.

Both sides use valid/ready handshakes. The input side only accepts a word when the buffer is sure to have room for both of its halfwords.

Top module: `insn_aligner`

## Requirements
- R1: A first halfword whose bits [15:13] are anything other than 3'b111 starts a 16-bit instruction.
- R2: A first halfword with bits [15:13] = 3'b111 and bits [12:11] = 2'b00 also starts a 16-bit instruction.
- R3: A first halfword with bits [15:13] = 3'b111 and bits [12:11] not 2'b00 starts a 32-bit instruction. Such an instruction is output as {first halfword, second halfword} with `out_is32` = 1. A 16-bit instruction is output in `out_insn[15:0]`, with bits [31:16] zero and `out_is32` = 0.
- R4: Bits [15:0] of a fetch word hold the halfword at the lower address. A 32-bit instruction whose first halfword is bits [31:16] of one word is completed by bits [15:0] of the next accepted word.
- R5: After each accepted instruction, `out_addr` advances by 4 if that instruction was 32 bits long and by 2 if it was 16 bits long.
- R6: `out_valid` is high only when a complete instruction is buffered. While `out_valid` is high and `out_ready` is low, `out_insn`, `out_is32` and `out_addr` hold steady.
- R7: `in_ready` is low whenever more than DEPTH-2 halfwords are buffered (DEPTH = 4 by default), so the buffer never overflows.
- R8: In a cycle with `flush` high, `out_valid` and `in_ready` are low. All buffered halfwords are discarded, and the next emitted instruction carries address `flush_addr` with bit 0 cleared.
- R9: If bit 1 of `flush_addr` is set, only bits [31:16] of the first word accepted after the flush enter the buffer.
- R10: After reset the buffer is empty, `out_valid` is low, `in_ready` is high and `out_addr` equals RESET_ADDR (0 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the buffer and restart at `flush_addr` |
| flush_addr | input | AW | Byte address of the new stream start |
| in_valid | input | 1 | Fetch word available |
| in_ready | output | 1 | Aligner accepts the fetch word this cycle |
| in_data | input | 32 | Fetch word, lower-address halfword in [15:0] |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | Consumer takes the instruction this cycle |
| out_insn | output | 32 | Instruction bits, formatted per R3 |
| out_is32 | output | 1 | 1 for a 32-bit instruction |
| out_addr | output | AW | Byte address of the instruction's first halfword |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:

- **Straddling instructions.** A 32-bit instruction crosses a fetch-word boundary. A design that dropped the leftover halfword, or swapped the two halves, would emit wrong bits or shift every later address.
- **The 3'b111 prefix with [12:11] = 2'b00.** If this case is decoded as 32 bits long, the following instruction is swallowed.
- **Incomplete instructions.** Only the first half of a 32-bit instruction is buffered. Emitting it early would show up as a premature `out_valid`.
- **Flushes.** The bench flushes with stale data still queued, and flushes to a halfword-aligned address. Errors would appear as leaked old halfwords or an unskipped lower halfword.
- **Sustained back-pressure.** A design with a wrong stall threshold would overwrite queued halfwords or present a changing instruction while stalled.

// File: rtl/insn_align_pkg.sv
package insn_align_pkg;

  typedef logic [15:0] half_t;

  // True when the halfword begins a two-halfword instruction.
  function automatic logic starts_wide(half_t h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction

endpackage

// File: rtl/half_shift_buf.sv
module half_shift_buf #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic [1:0]                 pop_n,
  input  logic [1:0]                 push_n,
  input  insn_align_pkg::half_t      push_h0,
  input  insn_align_pkg::half_t      push_h1,
  output insn_align_pkg::half_t      head0,
  output insn_align_pkg::half_t      head1,
  output logic [CW-1:0]              count
);
  import insn_align_pkg::*;

  half_t         q   [DEPTH];
  half_t         nxt [DEPTH];
  logic [CW-1:0] cnt_q;

  // Entry i after the update is old entry i+pop, or a freshly pushed halfword.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      int j;
      nxt[i] = q[i];
      src    = i + int'(pop_n);
      j      = src - int'(cnt_q);
      if (src < int'(cnt_q)) begin
        for (int k = 0; k < DEPTH; k++)
          if (k == src) nxt[i] = q[k];
      end else if (j == 0 && push_n != 2'd0) begin
        nxt[i] = push_h0;
      end else if (j == 1 && push_n == 2'd2) begin
        nxt[i] = push_h1;
      end
    end
  end

  always_ff @(posedge clk) begin
    q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_q - CW'(pop_n) + CW'(push_n);
  end

  assign head0 = q[0];
  assign head1 = q[1];
  assign count = cnt_q;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= DEPTH);
  p_pop_backed_r6: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= cnt_q);

endmodule

// File: rtl/insn_head_view.sv
module insn_head_view #(
  parameter int CW = 3
) (
  input  insn_align_pkg::half_t h0,
  input  insn_align_pkg::half_t h1,
  input  logic [CW-1:0]         count,
  output logic                  complete,
  output logic                  is32,
  output logic [31:0]           insn
);
  import insn_align_pkg::*;

  always_comb begin
    is32     = starts_wide(h0);
    complete = (count >= CW'(2)) || ((count == CW'(1)) && !is32);
    insn     = is32 ? {h0, h1} : {16'h0000, h0};
  end

endmodule

// File: rtl/insn_aligner.sv
module insn_aligner #(
  parameter int          AW         = 32,
  parameter int          DEPTH      = 4,
  parameter logic [31:0] RESET_ADDR = 32'h0,
  localparam int         CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_insn,
  output logic          out_is32,
  output logic [AW-1:0] out_addr
);
  import insn_align_pkg::*;

  logic [AW-1:0] pc_q;
  logic          skip_q;
  logic [CW-1:0] count;
  half_t         head0, head1, push_h0;
  logic          complete, head_is32;
  logic          accept, emit;
  logic [1:0]    pop_n, push_n;
  logic [AW-1:0] step;

  half_shift_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clr     (flush),
    .pop_n   (pop_n),
    .push_n  (push_n),
    .push_h0 (push_h0),
    .push_h1 (in_data[31:16]),
    .head0   (head0),
    .head1   (head1),
    .count   (count)
  );

  insn_head_view #(.CW(CW)) u_view (
    .h0       (head0),
    .h1       (head1),
    .count    (count),
    .complete (complete),
    .is32     (head_is32),
    .insn     (out_insn)
  );

  assign in_ready  = !flush && (count <= CW'(DEPTH - 2));
  assign out_valid = !flush && complete;
  assign out_is32  = head_is32;
  assign out_addr  = pc_q;

  assign accept  = in_valid && in_ready;
  assign emit    = out_valid && out_ready;
  assign pop_n   = emit ? (head_is32 ? 2'd2 : 2'd1) : 2'd0;
  assign push_n  = accept ? (skip_q ? 2'd1 : 2'd2) : 2'd0;
  assign push_h0 = skip_q ? in_data[31:16] : in_data[15:0];
  assign step    = {{(AW-3){1'b0}}, head_is32, !head_is32, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_ADDR[AW-1:0];
      skip_q <= 1'b0;
    end else if (flush) begin
      pc_q   <= flush_addr & ~{{(AW-1){1'b0}}, 1'b1};
      skip_q <= flush_addr[1];
    end else begin
      if (accept) skip_q <= 1'b0;
      if (emit)   pc_q   <= pc_q + step;
    end
  end

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=>
      out_addr == $past(out_addr) + ($past(out_is32) ? AW'(4) : AW'(2)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (flush || (out_valid && $stable(out_insn) && $stable(out_addr))));
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (count > CW'(DEPTH - 2)) |-> !in_ready);
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!out_valid && !in_ready));

endmodule

// File: tb/insn_aligner_tb.sv
module insn_aligner_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [31:0]   out_insn;
  logic          out_is32;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  insn_aligner u_dut (
    .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_is32(out_is32), .out_addr(out_addr)
  );

  // Fetch words (lower-address halfword in [15:0]) and expected instructions.
  localparam int NW = 6;
  localparam int NE = 8;
  localparam logic [31:0] WORDS [NW] = '{
    32'hF000_1234, 32'hE005_8001, 32'hABCD_E800,
    32'h0011_F800, 32'hFFFF_4000, 32'h7777_0000 };
  localparam logic [31:0] EXP_INSN [NE] = '{
    32'h0000_1234, 32'hF000_8001, 32'h0000_E005, 32'hE800_ABCD,
    32'hF800_0011, 32'h0000_4000, 32'hFFFF_0000, 32'h0000_7777 };
  localparam logic EXP_W [NE] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] EXP_A [NE] = '{
    32'h00, 32'h02, 32'h06, 32'h08, 32'h0C, 32'h10, 32'h12, 32'h16 };
  localparam string EXP_TAG [NE] = '{
    "R1", "R4", "R2", "R3", "R3", "R5", "R4", "R1" };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_flush(input logic [AW-1:0] a);
    flush = 1'b1;
    flush_addr = a;
    #1;
    chk(!out_valid && !in_ready, "R8 quiet during flush",
        {out_valid, in_ready}, 0);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    in_data = w;
    in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input logic [31:0] insn, input logic w,
                            input logic [AW-1:0] a, input string tag);
    int n = 0;
    out_ready = 1'b1;
    #1;
    while (!out_valid && n < 20) begin
      @(negedge clk);
      #1;
      n++;
    end
    chk(out_valid && out_insn == insn && out_is32 == w && out_addr == a, tag,
        {out_valid, out_is32, out_insn, out_addr[29:0]},
        {1'b1, w, insn, a[29:0]});
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ii = 0;
    int oi = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R10: reset state
    chk(!out_valid, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready, "R10 in_ready after reset", in_ready, 1);
    chk(out_addr == '0, "R10 out_addr after reset", out_addr, 0);

    // Table walk with irregular consumer back-pressure.
    for (int cyc = 0; cyc < 300 && oi < NE; cyc++) begin
      @(negedge clk);
      in_valid  = (ii < NW);
      in_data   = WORDS[(ii < NW) ? ii : 0];
      out_ready = (cyc % 3) != 1;
      #1;
      if (out_valid && out_ready) begin
        chk(out_insn == EXP_INSN[oi] && out_is32 == EXP_W[oi] &&
            out_addr == EXP_A[oi], EXP_TAG[oi],
            {out_is32, out_insn, out_addr[30:0]},
            {EXP_W[oi], EXP_INSN[oi], EXP_A[oi][30:0]});
        oi++;
      end
      if (in_valid && in_ready) ii++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(oi == NE, "R4 table fully emitted", oi, NE);
    #1;
    chk(!out_valid, "R6 nothing left after table", out_valid, 0);

    // R9: halfword-aligned restart skips the lower halfword.
    @(negedge clk);
    do_flush(32'h102);
    push(32'h2222_1111);
    expect_out(32'h0000_2222, 1'b0, 32'h102, "R9 skip lower half");

    // R8: flush with queued data discards it.
    do_flush(32'h200);
    push(32'h5555_1000);
    #1;
    chk(out_valid, "R6 data queued before flush", out_valid, 1);
    do_flush(32'h300);
    #1;
    chk(!out_valid, "R8 empty after flush", out_valid, 0);
    push(32'h6666_7777);
    expect_out(32'h0000_7777, 1'b0, 32'h300, "R8 restart address");
    expect_out(32'h0000_6666, 1'b0, 32'h302, "R5 after restart");

    // R6: half of a 32-bit instruction is not emitted.
    do_flush(32'h402);
    push(32'hF000_9999);
    #1;
    chk(!out_valid, "R6 incomplete wide held back", out_valid, 0);
    push(32'h1234_0042);
    expect_out(32'hF000_0042, 1'b1, 32'h402, "R4 wide across words");
    expect_out(32'h0000_1234, 1'b0, 32'h406, "R5 step after wide");

    // R7: stall when full, R6 hold under back-pressure.
    do_flush(32'h500);
    push(32'h0002_0001);
    push(32'h0004_0003);
    in_data = 32'h0006_0005;
    in_valid = 1'b1;
    #1;
    chk(!in_ready, "R7 stall when full", in_ready, 0);
    chk(out_valid && out_insn == 32'h1 && out_addr == 32'h500,
        "R6 head while stalled", {out_insn, out_addr}, {32'h1, 32'h500});
    repeat (3) @(negedge clk);
    #1;
    chk(!in_ready && out_insn == 32'h1 && out_addr == 32'h500,
        "R6 stable under back-pressure", {in_ready, out_insn}, {1'b0, 32'h1});
    in_valid = 1'b0;
    @(negedge clk);
    expect_out(32'h1, 1'b0, 32'h500, "R7 drain 1");
    expect_out(32'h2, 1'b0, 32'h502, "R7 drain 2");
    expect_out(32'h3, 1'b0, 32'h504, "R7 drain 3");
    expect_out(32'h4, 1'b0, 32'h506, "R7 drain 4");
    #1;
    chk(!out_valid && in_ready, "R7 empty after drain",
        {out_valid, in_ready}, {1'b0, 1'b1});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule